// File: doc/BRIEF.md
# Boundary Scan Ring with Bus-Enable Cell

This block is the boundary register of a test access port: a 107-cell chain between the serial test input and the serial test output. Each cell has a shift stage and a parallel update latch. A separate TAP controller supplies the capture, shift and update strobes, a test-reset indication and a two-bit code for the current instruction. The block watches the device pins and takes a snapshot of them into the shift stages. While the external-test instruction is current, it drives the data output bus from the update latches.

One cell has no pin. Its update latch decides whether the data output bus is driven during external test. This latch comes out of power-up reset and out of test reset at 1 (bus driven), so the bus keeps driving until software scans in a 0. Pin observations come from another clock domain. They go through a synchronizer clocked by the test clock before any capture.

Top module: `bscan_ring`

## Requirements
- R1: The chain is exactly 107 cells long. A pattern shifted in comes out unchanged and in order on `tdo_o` during the next 107 shift cycles.
- R2: `tdo_o` always shows cell 0. Each rising test-clock edge with `shift_i` high and a scan mode selected moves every cell one place toward cell 0 and loads `tdi_i` into cell 106. The shift stages are 0 after power-up reset.
- R3: A rising edge with `capture_i` high and a scan mode selected loads the observed pins into the shift stages. Cells 0 to 35 take `q_o[0]` to `q_o[35]`. Cell 47 takes `q_oe_o`. The remaining cells take `pin_i[0]` to `pin_i[69]` in ascending cell order. Capture wins over shift.
- R4: Every observed value passes through two test-clock flops. A change made just after an edge is not captured at the second rising edge after the change, but it is captured at the third.
- R5: A rising edge with `update_i` high and a scan mode selected copies all shift stages into the update latches. Under mode 2'b11 (external test), `q_o` equals update latches 0 to 35. Shifting alone does not change `q_o`.
- R6: Under mode 2'b11, `q_oe_o` equals update latch 47: 1 drives the bus, 0 releases it.
- R7: Update latch 47 is 1 after power-up reset and after any edge with `tlr_i` high. `tlr_i` does not change the other update latches, and the other latches reset to 0.
- R8: Under mode 2'b00 (no scan instruction), `q_o` and `q_oe_o` follow `func_q_i` and `func_oe_i`. The capture, shift and update strobes are then ignored.
- R9: Under mode 2'b10 (sample with bus off), `q_oe_o` is 0 and `q_o` follows `func_q_i`, while the chain still captures and shifts.
- R10: Shifting out captured data and shifting in new data happen in the same pass.
- R11: Under mode 2'b01 (sample/preload), the pins follow the functional inputs even after an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Asynchronous power-up reset, active low |
| tlr_i | input | 1 | TAP controller is in test-logic-reset |
| mode_i | input | 2 | Current instruction class: 00 none, 01 sample/preload, 10 sample bus-off, 11 external test |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out (cell 0) |
| pin_i | input | 70 | Observed device input pins |
| func_q_i | input | 36 | Data output bus from functional logic |
| func_oe_i | input | 1 | Bus enable from functional logic |
| q_o | output | 36 | Data output bus to the pads |
| q_oe_o | output | 1 | Data output bus enable to the pads |

## Verification
The bound checker tests the chain's movement on every cycle. It checks that cell 1 reaches `tdo_o` and `tdi_i` reaches the far end on each shift edge, that the update latches copy the shift stages exactly when an update is allowed and hold otherwise, and that test reset leaves the bus-enable latch at 1. The cell order of a capture, the synchronizer latency, the exact chain length and the output muxing under each mode depend on full scan passes and chosen pin patterns, so only the directed scenarios can show them.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   typedef enum logic [1:0] {
      BS_FUNC    = 2'b00,
      BS_PRELOAD = 2'b01,
      BS_HIZ     = 2'b10,
      BS_EXTEST  = 2'b11
   } bs_mode_e;
endpackage

// File: rtl/bscan_sync.sv
module bscan_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bscan_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bscan_shift.sv
module bscan_shift #(
   parameter int CELLS = 107
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic             sft_i,
   input  logic [CELLS-1:0] par_i,
   input  logic             tdi_i,
   output logic [CELLS-1:0] sh_o
);
   logic [CELLS-1:0] sh_q;
   logic [CELLS-1:0] nxt;

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      if (c == CELLS-1) begin : g_head
         assign nxt[c] = tdi_i;
      end else begin : g_body
         assign nxt[c] = sh_q[c+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (cap_i) sh_q <= par_i;
      else if (sft_i) sh_q <= nxt;
   end

   assign sh_o = sh_q;
endmodule

// File: rtl/bscan_latch.sv
module bscan_latch #(
   parameter int CELLS  = 107,
   parameter int OE_IDX = 47
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic             tlr_i,
   input  logic [CELLS-1:0] sh_i,
   output logic [CELLS-1:0] pre_o
);
   localparam logic [CELLS-1:0] RST_VAL = {{(CELLS-1){1'b0}}, 1'b1} << OE_IDX;

   logic [CELLS-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= RST_VAL;
      end else begin
         if (upd_i) pre_q <= sh_i;
         if (tlr_i) pre_q[OE_IDX] <= 1'b1;
      end
   end

   assign pre_o = pre_q;
endmodule

// File: rtl/bscan_ring.sv
module bscan_ring #(
   parameter  int CELLS       = 107,
   parameter  int OE_IDX      = 47,
   parameter  int Q_W         = 36,
   parameter  int SYNC_STAGES = 2,
   localparam int IN_W        = CELLS - 1 - Q_W
) (
   input  logic            tck_i,
   input  logic            rst_n_i,
   input  logic            tlr_i,
   input  logic [1:0]      mode_i,
   input  logic            capture_i,
   input  logic            shift_i,
   input  logic            update_i,
   input  logic            tdi_i,
   output logic            tdo_o,
   input  logic [IN_W-1:0] pin_i,
   input  logic [Q_W-1:0]  func_q_i,
   input  logic            func_oe_i,
   output logic [Q_W-1:0]  q_o,
   output logic            q_oe_o
);
   import bscan_pkg::*;

   if (OE_IDX < Q_W || OE_IDX >= CELLS) begin : g_bad_oe
      $error("enable cell must lie above the data bus cells and inside the chain");
   end
   if (IN_W < 1) begin : g_bad_in
      $error("chain too short for the data bus");
   end

   bs_mode_e         mode;
   logic             scan_sel;
   logic [CELLS-1:0] obs;
   logic [CELLS-1:0] obs_sync;
   logic [CELLS-1:0] sh_q;
   logic [CELLS-1:0] pre_q;

   assign mode     = bs_mode_e'(mode_i);
   assign scan_sel = (mode != BS_FUNC);

   for (genvar c = 0; c < CELLS; c++) begin : g_obs
      if (c < Q_W) begin : g_q
         assign obs[c] = q_o[c];
      end else if (c == OE_IDX) begin : g_oe
         assign obs[c] = q_oe_o;
      end else if (c < OE_IDX) begin : g_lo
         assign obs[c] = pin_i[c-Q_W];
      end else begin : g_hi
         assign obs[c] = pin_i[c-Q_W-1];
      end
   end

   bscan_sync #(.W(CELLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (tck_i),
      .rst_n (rst_n_i),
      .d_i   (obs),
      .q_o   (obs_sync)
   );

   bscan_shift #(.CELLS(CELLS)) u_shift (
      .clk   (tck_i),
      .rst_n (rst_n_i),
      .cap_i (capture_i & scan_sel),
      .sft_i (shift_i & scan_sel),
      .par_i (obs_sync),
      .tdi_i (tdi_i),
      .sh_o  (sh_q)
   );

   bscan_latch #(.CELLS(CELLS), .OE_IDX(OE_IDX)) u_latch (
      .clk   (tck_i),
      .rst_n (rst_n_i),
      .upd_i (update_i & scan_sel),
      .tlr_i (tlr_i),
      .sh_i  (sh_q),
      .pre_o (pre_q)
   );

   always_comb begin
      q_o    = func_q_i;
      q_oe_o = func_oe_i;
      case (mode)
         BS_EXTEST: begin
            q_o    = pre_q[Q_W-1:0];
            q_oe_o = pre_q[OE_IDX];
         end
         BS_HIZ:  q_oe_o = 1'b0;
         default: ;
      endcase
   end

   assign tdo_o = sh_q[0];
endmodule

// File: rtl/bscan_ring_chk.sv
module bscan_ring_chk #(
   parameter int CELLS  = 107,
   parameter int OE_IDX = 47
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tlr,
   input logic [1:0]       mode,
   input logic             cap,
   input logic             sft,
   input logic             upd,
   input logic             tdi,
   input logic             tdo,
   input logic [CELLS-1:0] sh,
   input logic [CELLS-1:0] pre
);
   logic sel;
   assign sel = (mode != 2'b00);

   AST_SHIFT_TO_TDO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && sft && !cap) |=> (tdo == $past(sh[1])));   // R2
   AST_SHIFT_FROM_TDI: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && sft && !cap) |=> (sh[CELLS-1] == $past(tdi)));   // R2
   AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && upd && !tlr) |=> (pre == $past(sh)));   // R5
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(sel && upd) && !tlr) |=> $stable(pre));   // R8
   AST_OE_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |=> pre[OE_IDX]);   // R7
endmodule

bind bscan_ring bscan_ring_chk #(.CELLS(CELLS), .OE_IDX(OE_IDX)) u_chk (
   .clk   (tck_i),
   .rst_n (rst_n_i),
   .tlr   (tlr_i),
   .mode  (mode_i),
   .cap   (capture_i),
   .sft   (shift_i),
   .upd   (update_i),
   .tdi   (tdi_i),
   .tdo   (tdo_o),
   .sh    (sh_q),
   .pre   (pre_q)
);

// File: tb/bscan_ring_tb.sv
module bscan_ring_tb;
   localparam int CELLS  = 107;
   localparam int OE_IDX = 47;
   localparam int Q_W    = 36;
   localparam int IN_W   = CELLS - 1 - Q_W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n, tlr, cap, sft, upd, tdi, tdo, func_oe, q_oe;
   logic [1:0]      mode;
   logic [IN_W-1:0] pin;
   logic [Q_W-1:0]  func_q, q;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bscan_ring u_dut (
      .tck_i(clk), .rst_n_i(rst_n), .tlr_i(tlr), .mode_i(mode),
      .capture_i(cap), .shift_i(sft), .update_i(upd), .tdi_i(tdi),
      .tdo_o(tdo), .pin_i(pin), .func_q_i(func_q), .func_oe_i(func_oe),
      .q_o(q), .q_oe_o(q_oe)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [CELLS-1:0] mkpat(input int s);
      logic [CELLS-1:0] r;
      for (int i = 0; i < CELLS; i++) r[i] = (((i * s) + (s / 3)) % 7) < 3;
      return r;
   endfunction

   function automatic logic [CELLS-1:0] exp_cap(input logic [Q_W-1:0] qv, input logic oev,
                                                input logic [IN_W-1:0] pv);
      logic [CELLS-1:0] r;
      int k;
      k = 0;
      for (int c = 0; c < CELLS; c++) begin
         if (c < Q_W) r[c] = qv[c];
         else if (c == OE_IDX) r[c] = oev;
         else begin r[c] = pv[k]; k++; end
      end
      return r;
   endfunction

   task automatic pulse_cap();
      @(negedge clk) cap = 1'b1;
      @(negedge clk) cap = 1'b0;
   endtask

   task automatic pulse_upd();
      @(negedge clk) upd = 1'b1;
      @(negedge clk) upd = 1'b0;
   endtask

   task automatic shift_pass(input logic [CELLS-1:0] pat, output logic [CELLS-1:0] got);
      for (int i = 0; i < CELLS; i++) begin
         @(negedge clk);
         got[i] = tdo;
         sft    = 1'b1;
         tdi    = pat[i];
      end
      @(negedge clk) sft = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R2 tdo after reset", 128'(tdo), 128'(1'b0));
      chk("R8 bus follows functional", 128'(q), 128'(func_q));
      chk("R8 enable follows functional", 128'(q_oe), 128'(func_oe));
      mode = 2'b11; #1;
      chk("R7 enable latch preset at power-up", 128'(q_oe), 128'(1'b1));
      chk("R5 data latches reset", 128'(q), 128'(0));
      mode = 2'b00;
   endtask

   task automatic t_sample();
      logic [CELLS-1:0] a, got, got2, p2;
      a = mkpat(5); p2 = mkpat(11);
      mode = 2'b01; func_q = a[Q_W-1:0]; func_oe = 1'b1; pin = a[CELLS-1:Q_W+1];
      repeat (4) @(negedge clk);
      #1 chk("R11 bus follows functional in preload", 128'(q), 128'(func_q));
      pulse_cap();
      shift_pass(p2, got);
      chk("R3 captured snapshot", 128'(got), 128'(exp_cap(func_q, 1'b1, pin)));
      shift_pass('0, got2);
      chk("R1 R10 pattern returns after 107 shifts", 128'(got2), 128'(p2));
   endtask

   task automatic t_sync();
      logic [CELLS-1:0] got;
      mode = 2'b01; pin[0] = 1'b0;
      repeat (4) @(negedge clk);
      @(negedge clk) pin[0] = 1'b1;
      @(negedge clk) cap = 1'b1;
      @(negedge clk) cap = 1'b0;
      shift_pass('0, got);
      chk("R4 not captured at second edge", 128'(got[Q_W]), 128'(1'b0));
      @(negedge clk) pin[0] = 1'b0;
      @(negedge clk);
      @(negedge clk) cap = 1'b1;
      @(negedge clk) cap = 1'b0;
      shift_pass('0, got);
      chk("R4 captured at third edge", 128'(got[Q_W]), 128'(1'b0));
      chk("R3 other cells intact", 128'(got), 128'(exp_cap(func_q, func_oe, pin)));
   endtask

   task automatic t_update(output logic [CELLS-1:0] p4);
      logic [CELLS-1:0] p3, got;
      p3 = mkpat(13); p3[OE_IDX] = 1'b1;
      p4 = mkpat(17); p4[OE_IDX] = 1'b0;
      mode = 2'b01;
      shift_pass(p3, got);
      pulse_upd();
      #1 chk("R11 preload does not reach pins", 128'(q), 128'(func_q));
      mode = 2'b11; #1;
      chk("R5 external test drives latches", 128'(q), 128'(p3[Q_W-1:0]));
      chk("R6 enable cell 1 drives bus", 128'(q_oe), 128'(1'b1));
      shift_pass(p4, got);
      #1 chk("R5 shifting leaves pins", 128'(q), 128'(p3[Q_W-1:0]));
      pulse_upd();
      #1 chk("R6 enable cell 0 releases bus", 128'(q_oe), 128'(1'b0));
      chk("R5 second update", 128'(q), 128'(p4[Q_W-1:0]));
   endtask

   task automatic t_tlr(input logic [CELLS-1:0] p4);
      @(negedge clk) tlr = 1'b1;
      @(negedge clk) tlr = 1'b0;
      #1 chk("R7 test reset presets enable", 128'(q_oe), 128'(1'b1));
      chk("R7 test reset keeps data latches", 128'(q), 128'(p4[Q_W-1:0]));
   endtask

   task automatic t_func(input logic [CELLS-1:0] p4);
      logic [CELLS-1:0] got;
      logic t0;
      mode = 2'b00; #1;
      chk("R8 bus follows functional", 128'(q), 128'(func_q));
      t0 = tdo;
      shift_pass(mkpat(19), got);
      chk("R8 shift ignored", 128'(got), 128'({CELLS{t0}}));
      pulse_cap();
      pulse_upd();
      mode = 2'b11; #1;
      chk("R8 update ignored", 128'(q), 128'(p4[Q_W-1:0]));
      chk("R8 enable latch untouched", 128'(q_oe), 128'(1'b1));
      mode = 2'b01;
      shift_pass('0, got);
      chk("R8 capture ignored", 128'(got), 128'(p4));
   endtask

   task automatic t_hiz();
      logic [CELLS-1:0] got;
      mode = 2'b10; func_oe = 1'b1; func_q = ~func_q; #1;
      chk("R9 bus released", 128'(q_oe), 128'(1'b0));
      chk("R9 data follows functional", 128'(q), 128'(func_q));
      repeat (4) @(negedge clk);
      pulse_cap();
      shift_pass('0, got);
      chk("R9 R3 capture while bus off", 128'(got), 128'(exp_cap(func_q, 1'b0, pin)));
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [CELLS-1:0] p4;
      rst_n = 1'b0; tlr = 1'b0; cap = 1'b0; sft = 1'b0; upd = 1'b0; tdi = 1'b0;
      mode = 2'b00; pin = '0; func_q = 36'h5_A5A5_A5A5; func_oe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sample();
      t_sync();
      t_update(p4);
      t_tlr(p4);
      t_func(p4);
      t_hiz();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule